// File: doc/BRIEF.md
# Seconds-Counter Register Port (two-wire slave)

This block is the serial access path to a small register space. The space holds a 32-bit seconds counter, seen as four bytes, plus one control byte and one trickle-charge byte. The block takes the raw two-wire clock and data levels, synchronizes them to the system clock and oversamples them. It detects START and STOP conditions, answers to one fixed 7-bit device address, and moves bytes in both directions through a byte pointer that wraps around. For reads it takes the counter bytes from an input bus. For writes it issues one-cycle strobes with the data byte. It holds the control and trickle-charge bytes itself and decodes the trickle-enable pattern.

The sequencing is a state machine with these states:

| State | Meaning |
|-------|---------|
| `ST_IDLE` | Waiting for a START. |
| `ST_ADDR` | Shifting in the address byte. |
| `ST_ADDR_ACK` | Acknowledging the address. |
| `ST_PTR` | Shifting in the pointer byte. |
| `ST_PTR_ACK` | Acknowledging the pointer byte. |
| `ST_WDATA` | Shifting in a data byte. |
| `ST_WDATA_ACK` | Acknowledging a data byte. |
| `ST_RDATA` | Shifting a byte out. |
| `ST_RACK` | Sampling the master's acknowledge. |
| `ST_SKIP` | Bus ignored until the next START or STOP. |

The transitions are as follows:
- START enters `ST_ADDR` from any state.
- STOP enters `ST_IDLE` from any state.
- Power failure forces `ST_IDLE`.
- After eight bits, `ST_ADDR` goes to `ST_ADDR_ACK` if the address matches and to `ST_SKIP` if it does not.
- When its acknowledge ends, `ST_ADDR_ACK` goes to `ST_RDATA` for a read or to `ST_PTR` for a write.
- `ST_PTR` goes to `ST_PTR_ACK`, and then to `ST_WDATA`.
- `ST_WDATA` and `ST_WDATA_ACK` alternate.
- `ST_RDATA` goes to `ST_RACK` after eight bits.
- `ST_RACK` goes back to `ST_RDATA` on an acknowledge and to `ST_SKIP` on a not-acknowledge.

Top module: `secreg_slave`

## Requirements
- R1: After reset the data line is released, the control and trickle-charge bytes read 00h, the pointer is 00h and `trickle_en` is 0.
- R2: Address byte D0h (write) or D1h (read) is acknowledged. Any other address byte is not acknowledged, and no later byte is acknowledged or written until the next START or STOP.
- R3: In a write, the pointer byte and every data byte are acknowledged by holding the data line low through the high phase of the ninth clock.
- R4: The first byte after D0h loads the pointer (a value above 05h loads 00h). Each further byte raises the write strobe of the pointed register and then advances the pointer.
- R5: The pointer advances from 05h to 00h, on reads and on writes.
- R6: A read starts at the pointer left by the last transaction. Index 00h..03h returns counter bits 7:0..31:24, index 04h returns control and index 05h returns trickle-charge. Bytes are sent MSB first.
- R7: In a read, the next byte is sent after the master acknowledges. After a not-acknowledge the data line stays released.
- R8: A repeated START aborts the current transfer and begins a new address phase.
- R9: `trickle_en` is 1 only while bits 7:4 of register 05h are 1010.
- R10: While `pwr_fail` is high nothing is acknowledged, no strobe is raised, and the pointer and registers keep their values.
- R11: `wr_stb` is one-hot or zero, lasts one cycle, and `wr_data` carries the byte in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock level |
| sda_in | input | 1 | Bus data level (wired) |
| pwr_fail | input | 1 | Supply below the fail threshold |
| cnt_in | input | 32 | Seconds counter value for reads |
| sda_pull | output | 1 | 1 pulls the data line low |
| wr_stb | output | 6 | One-hot write strobe per register index |
| wr_data | output | 8 | Byte written with the strobe |
| ctrl_q | output | 8 | Control register |
| trk_q | output | 8 | Trickle-charge register |
| trickle_en | output | 1 | Trickle charger enable decode |

## Verification
The hardest situations to reach are the pointer wrap inside a read burst that follows a repeated START, and the read-back proving that an ignored transfer touched nothing. The stimulus writes near the top of the space so that the pointer wraps mid-write. It then issues a repeated START and reads six bytes, so the read wraps too. Transfers to a foreign address and transfers made during power failure are each followed by a clean read of the pointer and the control register. That read shows the state is intact.

// File: rtl/secreg_pkg.sv
package secreg_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_SKIP
    } sr_state_t;
endpackage

// File: rtl/secreg_sync.sv
module secreg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic sda_lvl
);
    logic [STAGES:0] scl_sh, sda_sh;
    logic scl_c, scl_p, sda_c, sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
        end else begin
            scl_sh <= {scl_sh[STAGES-1:0], scl_raw};
            sda_sh <= {sda_sh[STAGES-1:0], sda_raw};
        end
    end

    assign scl_c     = scl_sh[STAGES-1];
    assign scl_p     = scl_sh[STAGES];
    assign sda_c     = sda_sh[STAGES-1];
    assign sda_p     = sda_sh[STAGES];
    assign scl_rise  = scl_c & ~scl_p;
    assign scl_fall  = ~scl_c & scl_p;
    assign start_det = scl_c & scl_p & sda_p & ~sda_c;
    assign stop_det  = scl_c & scl_p & ~sda_p & sda_c;
    assign sda_lvl   = sda_c;
endmodule

// File: rtl/secreg_regs.sv
module secreg_regs #(
    parameter int CNT_BYTES = 4,
    localparam int NREG = CNT_BYTES + 2,
    localparam int PW = $clog2(NREG)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NREG-1:0]        wr_stb,
    input  logic [7:0]             wr_data,
    input  logic [CNT_BYTES*8-1:0] cnt_in,
    input  logic [PW-1:0]          rd_idx,
    output logic [7:0]             rd_byte,
    output logic [7:0]             ctrl_q,
    output logic [7:0]             trk_q,
    output logic                   trickle_en
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= 8'h00;
            trk_q  <= 8'h00;
        end else begin
            if (wr_stb[CNT_BYTES])   ctrl_q <= wr_data;
            if (wr_stb[CNT_BYTES+1]) trk_q  <= wr_data;
        end
    end

    always_comb begin
        if (int'(rd_idx) < CNT_BYTES)       rd_byte = cnt_in[int'(rd_idx)*8 +: 8];
        else if (int'(rd_idx) == CNT_BYTES) rd_byte = ctrl_q;
        else                                rd_byte = trk_q;
    end

    assign trickle_en = (trk_q[7:4] == 4'b1010);

    // R9
    trickle_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trickle_en) |-> $past(wr_stb[CNT_BYTES+1]));
endmodule

// File: rtl/secreg_slave.sv
module secreg_slave
    import secreg_pkg::*;
#(
    parameter int         CNT_BYTES   = 4,
    parameter logic [6:0] DEV_ADDR    = 7'h68,
    parameter int         SYNC_STAGES = 2,
    localparam int NREG = CNT_BYTES + 2,
    localparam int PW   = $clog2(NREG)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_in,
    input  logic                   sda_in,
    input  logic                   pwr_fail,
    input  logic [CNT_BYTES*8-1:0] cnt_in,
    output logic                   sda_pull,
    output logic [NREG-1:0]        wr_stb,
    output logic [7:0]             wr_data,
    output logic [7:0]             ctrl_q,
    output logic [7:0]             trk_q,
    output logic                   trickle_en
);
    sr_state_t     state;
    logic [3:0]    bitcnt;
    logic [7:0]    shreg;
    logic [PW-1:0] ptr, ptr_nxt;
    logic          rw, mack;
    logic          rise, fall, start, stop, sda;
    logic [7:0]    rd_byte;
    logic          rx_done;

    secreg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_raw(scl_in), .sda_raw(sda_in),
        .scl_rise(rise), .scl_fall(fall), .start_det(start),
        .stop_det(stop), .sda_lvl(sda)
    );

    secreg_regs #(.CNT_BYTES(CNT_BYTES)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
        .cnt_in(cnt_in), .rd_idx(ptr), .rd_byte(rd_byte),
        .ctrl_q(ctrl_q), .trk_q(trk_q), .trickle_en(trickle_en)
    );

    assign ptr_nxt = (ptr == PW'(NREG-1)) ? '0 : ptr + 1'b1;
    assign rx_done = fall && (bitcnt == 4'd8);

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bitcnt  <= '0;
            shreg   <= '0;
            ptr     <= '0;
            rw      <= 1'b0;
            mack    <= 1'b0;
            wr_stb  <= '0;
            wr_data <= '0;
        end else begin
            wr_stb <= '0;
            if (pwr_fail) begin
                state <= ST_IDLE;
            end else if (start) begin
                state  <= ST_ADDR;
                bitcnt <= '0;
            end else if (stop) begin
                state <= ST_IDLE;
            end else begin
                unique case (state)
                    ST_IDLE, ST_SKIP: ;
                    ST_ADDR: begin
                        if (rise && bitcnt < 4'd8) begin
                            shreg  <= {shreg[6:0], sda};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (rx_done) begin
                            if (shreg[7:1] == DEV_ADDR) begin
                                rw    <= shreg[0];
                                state <= ST_ADDR_ACK;
                            end else begin
                                state <= ST_SKIP;
                            end
                        end
                    end
                    ST_PTR: begin
                        if (rise && bitcnt < 4'd8) begin
                            shreg  <= {shreg[6:0], sda};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (rx_done) begin
                            ptr   <= (shreg > 8'(NREG-1)) ? '0 : shreg[PW-1:0];
                            state <= ST_PTR_ACK;
                        end
                    end
                    ST_WDATA: begin
                        if (rise && bitcnt < 4'd8) begin
                            shreg  <= {shreg[6:0], sda};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (rx_done) begin
                            wr_stb  <= NREG'(1) << ptr;
                            wr_data <= shreg;
                            ptr     <= ptr_nxt;
                            state   <= ST_WDATA_ACK;
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (fall) begin
                            bitcnt <= '0;
                            if (rw) begin
                                shreg <= rd_byte;
                                ptr   <= ptr_nxt;
                                state <= ST_RDATA;
                            end else begin
                                state <= ST_PTR;
                            end
                        end
                    end
                    ST_PTR_ACK, ST_WDATA_ACK: begin
                        if (fall) begin
                            bitcnt <= '0;
                            state  <= ST_WDATA;
                        end
                    end
                    ST_RDATA: begin
                        if (fall) begin
                            if (bitcnt == 4'd7) begin
                                bitcnt <= '0;
                                state  <= ST_RACK;
                            end else begin
                                shreg  <= {shreg[6:0], 1'b0};
                                bitcnt <= bitcnt + 1'b1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (rise) mack <= ~sda;
                        if (fall) begin
                            if (mack) begin
                                shreg <= rd_byte;
                                ptr   <= ptr_nxt;
                                state <= ST_RDATA;
                            end else begin
                                state <= ST_SKIP;
                            end
                        end
                    end
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_PTR_ACK, ST_WDATA_ACK: sda_pull = 1'b1;
            ST_RDATA:                              sda_pull = ~shreg[7];
            default:                               sda_pull = 1'b0;
        endcase
    end

    // R10
    pf_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> !sda_pull);
    // R10
    pf_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> (wr_stb == '0));
    // R11
    stb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_stb));
    // R11
    stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb != '0) |=> (wr_stb == '0));
    // R5
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= PW'(NREG-1));
endmodule

// File: tb/secreg_slave_test.sv
`timescale 1ns/1ps
module secreg_slave_test;
    localparam int Q = 10;
    localparam logic [31:0] CNT = 32'h8C4E_19F7;

    logic clk = 1'b0, rst_n = 1'b0;
    logic scl = 1'b1, m_sda = 1'b1, pwr_fail = 1'b0;
    logic sda_pull, trickle_en;
    logic [5:0] wr_stb;
    logic [7:0] wr_data, ctrl_q, trk_q;
    logic sda_line;

    int vectors = 0, fails = 0;
    bit done = 0;
    int ptr_m = 0;
    logic [7:0] regm [0:5];
    int got_q[$], exp_q[$];

    always #2 clk = ~clk;
    assign sda_line = m_sda & ~sda_pull;

    secreg_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
        .pwr_fail(pwr_fail), .cnt_in(CNT), .sda_pull(sda_pull),
        .wr_stb(wr_stb), .wr_data(wr_data), .ctrl_q(ctrl_q),
        .trk_q(trk_q), .trickle_en(trickle_en)
    );

    always @(negedge clk) begin
        if (wr_stb != 0) begin
            for (int i = 0; i < 6; i++)
                if (wr_stb[i]) got_q.push_back(i * 256 + int'(wr_data));
        end
    end

    task automatic chk(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic waitc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; waitc(Q); scl = 1'b1; waitc(Q);
        m_sda = 1'b0; waitc(Q); scl = 1'b0; waitc(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; waitc(Q); scl = 1'b1; waitc(Q);
        m_sda = 1'b1; waitc(2 * Q);
    endtask

    // one clock pulse, returns the line level sampled mid-high
    task automatic pulse(output logic lvl);
        waitc(2 * Q); scl = 1'b1; waitc(Q);
        lvl = sda_line; waitc(Q); scl = 1'b0;
    endtask

    task automatic wb(logic [7:0] b, bit exp_ack, string req);
        logic l;
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; pulse(l);
        end
        m_sda = 1'b1; pulse(l);
        chk(req, int'(!l), int'(exp_ack));
    endtask

    task automatic rb(logic [7:0] exp, bit ack, string req);
        logic l; logic [7:0] got;
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            pulse(l); got[i] = l;
        end
        m_sda = ack ? 1'b0 : 1'b1; pulse(l);
        chk(req, int'(got), int'(exp));
    endtask

    function automatic logic [7:0] mval(int idx);
        return (idx < 4) ? CNT[idx*8 +: 8] : regm[idx];
    endfunction

    function automatic int nxt(int p);
        return (p == 5) ? 0 : p + 1;
    endfunction

    task automatic mwrite(logic [7:0] d, string req);
        wb(d, 1'b1, req);
        exp_q.push_back(ptr_m * 256 + int'(d));
        if (ptr_m >= 4) regm[ptr_m] = d;
        ptr_m = nxt(ptr_m);
    endtask

    task automatic mread(bit ack, string req);
        rb(mval(ptr_m), ack, req);
        ptr_m = nxt(ptr_m);
    endtask

    task automatic set_ptr(logic [7:0] p, string req);
        wb(p, 1'b1, req);
        ptr_m = (p > 5) ? 0 : int'(p);
    endtask

    task automatic chk_strobes(string req);
        waitc(4);
        chk(req, got_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            chk(req, got_q[i], exp_q[i]);
        got_q.delete(); exp_q.delete();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        waitc(100000);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        regm[4] = 8'h00; regm[5] = 8'h00;
        waitc(5); rst_n = 1'b1; waitc(5);
        // R1 reset state
        chk("R1 sda_pull", int'(sda_pull), 0);
        chk("R1 ctrl_q", int'(ctrl_q), 0);
        chk("R1 trk_q", int'(trk_q), 0);
        chk("R1 trickle_en", int'(trickle_en), 0);

        // R1 R6 R7: read from reset pointer, ACK then NACK
        bus_start(); wb(8'hD1, 1'b1, "R2 read addr");
        mread(1'b1, "R6 first byte"); mread(1'b0, "R7 after ack");
        chk("R7 released after nack", int'(sda_pull), 0);
        bus_stop();

        // R3 R4 R5 R9: write control and trickle, pointer wraps
        bus_start(); wb(8'hD0, 1'b1, "R2 write addr");
        set_ptr(8'h04, "R3 ptr ack");
        mwrite(8'h5A, "R3 data ack"); mwrite(8'hA3, "R3 data ack");
        bus_stop(); chk_strobes("R4 strobes");
        chk("R11 ctrl_q", int'(ctrl_q), 8'h5A);
        chk("R9 enable 1010", int'(trickle_en), 1);

        bus_start(); wb(8'hD1, 1'b1, "R2 read addr");
        mread(1'b0, "R5 write wrap"); bus_stop();

        // R5 R8 R9: write wraps, repeated start, read burst wraps
        bus_start(); wb(8'hD0, 1'b1, "R2 write addr");
        set_ptr(8'h05, "R3 ptr ack");
        mwrite(8'h3B, "R3 data ack"); mwrite(8'h77, "R5 wrap write");
        bus_start(); wb(8'hD1, 1'b1, "R8 repeated start");
        for (int i = 0; i < 5; i++) mread(1'b1, "R5 R6 burst");
        mread(1'b0, "R5 read wrap");
        bus_stop(); chk_strobes("R5 strobes");
        chk("R9 pattern 0011", int'(trickle_en), 0);

        // R4 pointer above range
        bus_start(); wb(8'hD0, 1'b1, "R2 write addr");
        set_ptr(8'h09, "R4 big ptr"); bus_stop();
        bus_start(); wb(8'hD1, 1'b1, "R2 read addr");
        mread(1'b0, "R4 big ptr loads 00"); bus_stop();

        // R2 foreign addresses ignored
        bus_start(); wb(8'hA0, 1'b0, "R2 foreign nack");
        wb(8'h04, 1'b0, "R2 skip"); wb(8'hFF, 1'b0, "R2 skip");
        bus_stop();
        bus_start(); wb(8'hD2, 1'b0, "R2 foreign nack"); bus_stop();
        chk_strobes("R2 no strobes");
        bus_start(); wb(8'hD1, 1'b1, "R2 read addr");
        mread(1'b0, "R2 ptr intact"); bus_stop();

        // R10 power fail
        pwr_fail = 1'b1;
        bus_start(); wb(8'hD0, 1'b0, "R10 no ack");
        wb(8'h04, 1'b0, "R10 no ack"); wb(8'h00, 1'b0, "R10 no ack");
        bus_stop(); chk_strobes("R10 no strobes");
        pwr_fail = 1'b0; waitc(Q);
        bus_start(); wb(8'hD1, 1'b1, "R10 recover");
        mread(1'b0, "R10 ptr kept"); bus_stop();
        chk("R10 ctrl kept", int'(ctrl_q), 8'h5A);

        // R9 high nibble 1010 with other low nibble
        bus_start(); wb(8'hD0, 1'b1, "R2 write addr");
        set_ptr(8'h05, "R3 ptr ack"); mwrite(8'hA5, "R3 data ack");
        bus_stop(); chk_strobes("R11 strobes");
        chk("R9 enable A5", int'(trickle_en), 1);

        finish_run();
    end
endmodule